// File: doc/BRIEF.md
# Rescheduled ARX Quarter-Round Datapath

This block performs one quarter-round of a 32-bit add-rotate-xor hash compression on four state words. The message/constant addition that normally opens the next round is pulled forward into the tail of the current round. As a result, the state word `a` leaves each round already carrying its next addend, and the next round's first step needs only `a + b`. This keeps the longest combinational chain at four modular adders and four XORs. In the final round the pulled-forward addition must not happen, so a select chooses the plain `a` for that round.

The combinational core sits inside a small registered wrapper. A `load` pulse captures a starting state and folds the first round's message/constant pair into `a`. Each `step` pulse then applies one quarter-round. The caller supplies the current round's second pair and the next round's first pair, and flags the final round. Message permutation and constant storage stay outside the block. All message and constant words arrive on ports.

Top module: `arx_qround_iter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four state outputs become zero.
- R2: A `load` pulse sets `b_q`, `c_q` and `d_q` to `init_b`, `init_c` and `init_d` one cycle later. It sets `a_q` to `init_a + (m_first xor c_first)` modulo 2^32.
- R3: When `load` and `step` are high in the same cycle, `load` wins and the step inputs have no effect.
- R4: With neither `load` nor `step` high, all four state outputs hold their values.
- R5: A `step` with `last_round` low leaves `b_q`, `c_q` and `d_q` equal to one standard quarter-round of the held state. That round is: `a+=b` (the held `a` already carries its addend); `d=rotr(d^a,16)`; `c+=d`; `b=rotr(b^c,12)`; `a+=b+(m_cur_odd^c_cur_even)`; `d=rotr(d^a,8)`; `c+=d`; `b=rotr(b^c,7)`. Here rotr rotates toward the LSB. `a_q` equals that round's `a` plus `(m_next_even xor c_next_odd)`.
- R6: A `step` with `last_round` high leaves `a_q` equal to the plain quarter-round `a`. `m_next_even` and `c_next_odd` then have no effect on any output.
- R7: A load followed by N steps, with `last_round` high on the last step only, gives outputs identical to N chained unscheduled quarter-rounds. Each round adds `m_even^c_odd` first and `m_odd^c_even` second.
- R8: Every addition wraps modulo 2^32, including operands at all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture starting state |
| init_a | input | 32 | Starting word a (plain) |
| init_b | input | 32 | Starting word b |
| init_c | input | 32 | Starting word c |
| init_d | input | 32 | Starting word d |
| m_first | input | 32 | First round's even-index message word |
| c_first | input | 32 | First round's odd-index constant word |
| step | input | 1 | Apply one quarter-round |
| m_cur_odd | input | 32 | Current round's odd-index message word |
| c_cur_even | input | 32 | Current round's even-index constant word |
| m_next_even | input | 32 | Next round's even-index message word |
| c_next_odd | input | 32 | Next round's odd-index constant word |
| last_round | input | 1 | Final round: store plain a |
| a_q | output | 32 | State word a |
| b_q | output | 32 | State word b |
| c_q | output | 32 | State word c |
| d_q | output | 32 | State word d |

## Verification
The assertions assume that `load`, `step`, `last_round` and every data word are known and stable around each rising edge once reset is released. They also assume `load` and `step` stay low during reset. The stimulus respects this by changing inputs only on falling edges and holding the control pulses low throughout reset. It returns `load` and `step` to zero after every pulse. The data words are constant patterns or come from a deterministic generator, so no unknown value ever reaches the state registers.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W = 32;
  localparam int ROT_D1 = 16;
  localparam int ROT_B1 = 12;
  localparam int ROT_D2 = 8;
  localparam int ROT_B2 = 7;

  typedef logic [WORD_W-1:0] word_t;

  // rotate toward the least significant bit
  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // message/constant mixing term
  function automatic word_t mc_term(word_t m, word_t k);
    return m ^ k;
  endfunction
endpackage

// File: rtl/arx_half_mix.sv
module arx_half_mix
  import arx_pkg::*;
#(
  parameter int ROT_D = 16,
  parameter int ROT_B = 12
) (
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t addend,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a_n, c_n, d_n;

  assign a_n = a_i + b_i + addend;
  assign d_n = rotr(d_i ^ a_n, ROT_D);
  assign c_n = c_i + d_n;
  assign b_o = rotr(b_i ^ c_n, ROT_B);
  assign a_o = a_n;
  assign c_o = c_n;
  assign d_o = d_n;
endmodule

// File: rtl/arx_qround_core.sv
module arx_qround_core
  import arx_pkg::*;
(
  input  word_t a_in,
  input  word_t b_in,
  input  word_t c_in,
  input  word_t d_in,
  input  word_t m_cur_odd,
  input  word_t c_cur_even,
  input  word_t m_next_even,
  input  word_t c_next_odd,
  input  logic  last_round,
  output word_t a_out,
  output word_t b_out,
  output word_t c_out,
  output word_t d_out,
  output word_t a_plain
);
  localparam word_t NO_ADDEND = '0;

  word_t a1, b1, c1, d1;
  word_t a2;
  word_t mc_cur, mc_next, a_ant;

  // first half: a arrives pre-added, so only a + b
  arx_half_mix #(.ROT_D(ROT_D1), .ROT_B(ROT_B1)) u_half1 (
    .a_i(a_in), .b_i(b_in), .c_i(c_in), .d_i(d_in), .addend(NO_ADDEND),
    .a_o(a1), .b_o(b1), .c_o(c1), .d_o(d1)
  );

  assign mc_cur = mc_term(m_cur_odd, c_cur_even);

  arx_half_mix #(.ROT_D(ROT_D2), .ROT_B(ROT_B2)) u_half2 (
    .a_i(a1), .b_i(b1), .c_i(c1), .d_i(d1), .addend(mc_cur),
    .a_o(a2), .b_o(b_out), .c_o(c_out), .d_o(d_out)
  );

  // anticipated addend of the following round, off the b/c/d chain
  assign mc_next = mc_term(m_next_even, c_next_odd);
  assign a_ant   = a2 + mc_next;
  assign a_plain = a2;
  assign a_out   = last_round ? a2 : a_ant;
endmodule

// File: rtl/arx_qround_iter.sv
module arx_qround_iter
  import arx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] init_a,
  input  logic [WORD_W-1:0] init_b,
  input  logic [WORD_W-1:0] init_c,
  input  logic [WORD_W-1:0] init_d,
  input  logic [WORD_W-1:0] m_first,
  input  logic [WORD_W-1:0] c_first,
  input  logic              step,
  input  logic [WORD_W-1:0] m_cur_odd,
  input  logic [WORD_W-1:0] c_cur_even,
  input  logic [WORD_W-1:0] m_next_even,
  input  logic [WORD_W-1:0] c_next_odd,
  input  logic              last_round,
  output logic [WORD_W-1:0] a_q,
  output logic [WORD_W-1:0] b_q,
  output logic [WORD_W-1:0] c_q,
  output logic [WORD_W-1:0] d_q
);
  word_t a_nx_w, b_nx_w, c_nx_w, d_nx_w;
  word_t a_plain_w;
  word_t a_seed_w;

  arx_qround_core u_core (
    .a_in(a_q), .b_in(b_q), .c_in(c_q), .d_in(d_q),
    .m_cur_odd(m_cur_odd), .c_cur_even(c_cur_even),
    .m_next_even(m_next_even), .c_next_odd(c_next_odd),
    .last_round(last_round),
    .a_out(a_nx_w), .b_out(b_nx_w), .c_out(c_nx_w), .d_out(d_nx_w),
    .a_plain(a_plain_w)
  );

  // starting a carries the first round's addend already
  assign a_seed_w = init_a + mc_term(m_first, c_first);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      d_q <= '0;
    end else if (load) begin
      a_q <= a_seed_w;
      b_q <= init_b;
      c_q <= init_c;
      d_q <= init_d;
    end else if (step) begin
      a_q <= a_nx_w;
      b_q <= b_nx_w;
      c_q <= c_nx_w;
      d_q <= d_nx_w;
    end
  end
endmodule

// File: rtl/arx_qround_chk.sv
module arx_qround_chk
  import arx_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  load,
  input logic  step,
  input logic  last_round,
  input word_t init_a,
  input word_t init_b,
  input word_t init_c,
  input word_t init_d,
  input word_t m_first,
  input word_t c_first,
  input word_t m_next_even,
  input word_t c_next_odd,
  input word_t a_plain,
  input word_t a_q,
  input word_t b_q,
  input word_t c_q,
  input word_t d_q
);
  logic seen_edge = 1'b0;
  always @(posedge clk) seen_edge <= 1'b1;

  always @(negedge clk) begin
    if (seen_edge && !rst_n)
      assert_reset_clear_R1: assert (a_q == '0 && b_q == '0 && c_q == '0 && d_q == '0);
  end

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (b_q == $past(init_b) && c_q == $past(init_c) && d_q == $past(init_d)
              && a_q == $past(init_a + (m_first ^ c_first))));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && step) |=> (d_q == $past(init_d) && b_q == $past(init_b)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(d_q)));

  assert_next_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !last_round) |=> a_q == $past(a_plain + (m_next_even ^ c_next_odd)));

  assert_last_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && last_round) |=> a_q == $past(a_plain));
endmodule

bind arx_qround_iter arx_qround_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .step(step), .last_round(last_round),
  .init_a(init_a), .init_b(init_b), .init_c(init_c), .init_d(init_d),
  .m_first(m_first), .c_first(c_first),
  .m_next_even(m_next_even), .c_next_odd(c_next_odd),
  .a_plain(a_plain_w),
  .a_q(a_q), .b_q(b_q), .c_q(c_q), .d_q(d_q)
);

// File: tb/tb_arx_qround_iter.sv
module tb_arx_qround_iter;
  import arx_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic  rst_n, load, step, last_round;
  word_t init_a, init_b, init_c, init_d, m_first, c_first;
  word_t m_cur_odd, c_cur_even, m_next_even, c_next_odd;
  word_t a_q, b_q, c_q, d_q;

  int n_chk = 0;
  int n_bad = 0;

  arx_qround_iter dut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .init_a(init_a), .init_b(init_b), .init_c(init_c), .init_d(init_d),
    .m_first(m_first), .c_first(c_first), .step(step),
    .m_cur_odd(m_cur_odd), .c_cur_even(c_cur_even),
    .m_next_even(m_next_even), .c_next_odd(c_next_odd),
    .last_round(last_round),
    .a_q(a_q), .b_q(b_q), .c_q(c_q), .d_q(d_q)
  );

  task automatic chk(string tag, word_t act, word_t exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // rotation built from a doubled word, independent of the RTL helper
  function automatic word_t rr(word_t x, int n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction

  // unscheduled quarter-round
  task automatic ref_qr(input word_t me, ko, mo, ke, inout word_t a, b, c, d);
    a = a + b + (me ^ ko);
    d = rr(d ^ a, 16);
    c = c + d;
    b = rr(b ^ c, 12);
    a = a + b + (mo ^ ke);
    d = rr(d ^ a, 8);
    c = c + d;
    b = rr(b ^ c, 7);
  endtask

  function automatic word_t lcg(word_t s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(word_t a, b, c, d, me, ko);
    init_a = a; init_b = b; init_c = c; init_d = d; m_first = me; c_first = ko;
    load = 1'b1;
    cyc();
    load = 1'b0;
  endtask

  task automatic do_step(word_t mo, ke, mn, kn, logic last);
    m_cur_odd = mo; c_cur_even = ke; m_next_even = mn; c_next_odd = kn;
    last_round = last; step = 1'b1;
    cyc();
    step = 1'b0; last_round = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    chk("R1 a", a_q, '0); chk("R1 b", b_q, '0);
    chk("R1 c", c_q, '0); chk("R1 d", d_q, '0);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_load_hold();
    do_load(32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888,
            32'h0F0F_0F0F, 32'h00FF_00FF);
    chk("R2 a", a_q, 32'h1111_2222 + (32'h0F0F_0F0F ^ 32'h00FF_00FF));
    chk("R2 b", b_q, 32'h3333_4444);
    chk("R2 c", c_q, 32'h5555_6666);
    chk("R2 d", d_q, 32'h7777_8888);
    m_cur_odd = 32'hDEAD_BEEF; m_next_even = 32'hCAFE_F00D;
    repeat (3) cyc();
    chk("R4 a", a_q, 32'h1111_2222 + (32'h0F0F_0F0F ^ 32'h00FF_00FF));
    chk("R4 d", d_q, 32'h7777_8888);
  endtask

  task automatic t_priority();
    init_a = 32'hA; init_b = 32'hB; init_c = 32'hC; init_d = 32'hD;
    m_first = 32'h0; c_first = 32'h1;
    m_cur_odd = 32'h1234_5678; c_cur_even = 32'h9ABC_DEF0;
    m_next_even = 32'h5; c_next_odd = 32'h6;
    load = 1'b1; step = 1'b1;
    cyc();
    load = 1'b0; step = 1'b0;
    chk("R3 a", a_q, 32'hB);
    chk("R3 b", b_q, 32'hB);
    chk("R3 d", d_q, 32'hD);
  endtask

  task automatic t_step_nonlast();
    word_t a, b, c, d;
    a = 32'h6A09_E667; b = 32'hBB67_AE85; c = 32'h3C6E_F372; d = 32'hA54F_F53A;
    do_load(a, b, c, d, 32'h0123_4567, 32'h243F_6A88);
    do_step(32'h89AB_CDEF, 32'h85A3_08D3, 32'hFEDC_BA98, 32'h1319_8A2E, 1'b0);
    ref_qr(32'h0123_4567, 32'h243F_6A88, 32'h89AB_CDEF, 32'h85A3_08D3, a, b, c, d);
    chk("R5 a", a_q, a + (32'hFEDC_BA98 ^ 32'h1319_8A2E));
    chk("R5 b", b_q, b);
    chk("R5 c", c_q, c);
    chk("R5 d", d_q, d);
  endtask

  task automatic t_last_ignores_next();
    word_t a, b, c, d;
    a = 32'h510E_527F; b = 32'h9B05_688C; c = 32'h1F83_D9AB; d = 32'h5BE0_CD19;
    ref_qr(32'h3, 32'h4, 32'h5, 32'h6, a, b, c, d);
    do_load(32'h510E_527F, 32'h9B05_688C, 32'h1F83_D9AB, 32'h5BE0_CD19, 32'h3, 32'h4);
    do_step(32'h5, 32'h6, 32'hFFFF_0000, 32'h0000_FFFF, 1'b1);
    chk("R6 a pairP", a_q, a);
    chk("R6 b pairP", b_q, b);
    do_load(32'h510E_527F, 32'h9B05_688C, 32'h1F83_D9AB, 32'h5BE0_CD19, 32'h3, 32'h4);
    do_step(32'h5, 32'h6, 32'h1357_9BDF, 32'h2468_ACE0, 1'b1);
    chk("R6 a pairQ", a_q, a);
    chk("R6 c pairQ", c_q, c);
    chk("R6 d pairQ", d_q, d);
  endtask

  task automatic t_chain();
    word_t me[11], ko[11], mo[10], ke[10];
    word_t s, a, b, c, d;
    s = 32'h0BAD_5EED;
    for (int i = 0; i < 11; i++) begin
      s = lcg(s); me[i] = s; s = lcg(s); ko[i] = s;
    end
    for (int i = 0; i < 10; i++) begin
      s = lcg(s); mo[i] = s; s = lcg(s); ke[i] = s;
    end
    a = 32'h0000_0001; b = 32'h8000_0000; c = 32'hFFFF_FFFF; d = 32'h1234_ABCD;
    do_load(a, b, c, d, me[0], ko[0]);
    for (int r = 0; r < 10; r++) begin
      do_step(mo[r], ke[r], me[r+1], ko[r+1], r == 9);
      ref_qr(me[r], ko[r], mo[r], ke[r], a, b, c, d);
      if (r == 4) chk("R7 mid b", b_q, b);
    end
    chk("R7 a", a_q, a);
    chk("R7 b", b_q, b);
    chk("R7 c", c_q, c);
    chk("R7 d", d_q, d);
  endtask

  task automatic t_wrap();
    word_t a, b, c, d, ones;
    ones = 32'hFFFF_FFFF;
    a = ones; b = ones; c = ones; d = ones;
    do_load(ones, ones, ones, ones, ones, 32'h0);
    chk("R8 a seed", a_q, 32'hFFFF_FFFE);
    do_step(ones, 32'h0, ones, 32'h0, 1'b1);
    ref_qr(ones, 32'h0, ones, 32'h0, a, b, c, d);
    chk("R8 a", a_q, a);
    chk("R8 c", c_q, c);
  endtask

  bit finished = 1'b0;

  initial begin
    rst_n = 1'b0; load = 1'b0; step = 1'b0; last_round = 1'b0;
    init_a = '0; init_b = '0; init_c = '0; init_d = '0;
    m_first = '0; c_first = '0;
    m_cur_odd = '0; c_cur_even = '0; m_next_even = '0; c_next_odd = '0;
    @(negedge clk);
    t_reset();
    t_load_hold();
    t_priority();
    t_step_nonlast();
    t_last_ignores_next();
    t_chain();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule